// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Converter

This block turns a two's complement fixed-point number into a 32-bit IEEE-754 single precision word. It has no clock. The fixed-point width and the position of the binary point are set by parameters. The float layout is also parameterised through the total, exponent and mantissa widths, and the default values give single precision. The converter sits between a fixed-point arithmetic coprocessor and a processor or memory that works in floating point. Each result word goes out in the same cycle that its fixed-point value arrives.

The conversion runs in five steps:

1. The sign is taken from the top bit of the input.
2. A negative input is negated to give an unsigned magnitude.
3. A priority encoder finds the highest set bit of the magnitude.
4. That bit position sets the left shift that normalises the magnitude.
5. The same position sets the biased exponent.

Zero is the only special case. It maps to positive zero. The block never generates infinity or NaN, and it truncates instead of rounding.

Top module: `fxp_to_fp32`

## Requirements
- R1: An all-zero input gives an all-zero output, which is positive zero with every bit clear.
- R2: For a non-zero input, output bit 31 (the sign) equals the most significant bit of the input.
- R3: For a non-zero input, output bits 30..23 hold 127 + p - RADIX_POS, where p is the bit index of the leading one of the magnitude.
- R4: Output bits 22..0 hold the magnitude bits below the leading one. These bits are left-aligned, and zeros fill the field when fewer than 23 bits exist. When more than 23 bits exist, the bits that do not fit are dropped.
- R5: The most negative input (only the top bit set) converts exactly. The output has sign 1, exponent 127 + FIXED_SIZE - 1 - RADIX_POS and mantissa 0.
- R6: The exponent field is never all ones, so no infinity or NaN is ever produced.
- R7: A power of two of either sign gives a mantissa field of zero.
- R8: The output for -v equals the output for v with only bit 31 changed, for every v with 0 < v < 2^(FIXED_SIZE-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fixedIn | input | FIXED_SIZE | Two's complement fixed-point value, with RADIX_POS fraction bits |
| floatOut | output | FLOAT_SIZE | Single precision result: sign, biased exponent, mantissa |

## Verification
The hardest cases to reach are those where negation and truncation meet. The most negative input has no positive counterpart. In the wide default configuration, the magnitude has more bits than the mantissa field can hold, so low bits must be dropped. A small 12-bit configuration is swept over every possible input. This covers every leading-one position, every sign and the zero-fill case, and it pairs each positive value with its negation. The 32-bit configuration is driven with the most negative value, all ones, both extremes, every power of two of both signs and a long pseudo-random stream. Together these exercise the truncation path.

// File: rtl/fxp_to_fp32_pkg.sv
package fxp_to_fp32_pkg;
  // strobes handed from control to datapath
  typedef struct packed {
    logic isZero;
    logic negate;
  } ctrl_t;
endpackage

// File: rtl/fxp_lead_one.sv
module fxp_lead_one #(
  parameter int WIDTH = 32,
  parameter int POS_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [POS_W-1:0] leadPos,
  output logic             leadFound
);
  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    leadPos   = '0;
    leadFound = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vecIn[i]) begin
        leadPos   = POS_W'(i);
        leadFound = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fxp_ctrl.sv
module fxp_ctrl
  import fxp_to_fp32_pkg::*;
#(
  parameter int FIXED_SIZE = 32
) (
  input  logic [FIXED_SIZE-1:0] fixedIn,
  output ctrl_t                 ctrl
);
  always_comb begin
    ctrl.isZero = ~|fixedIn;
    ctrl.negate = fixedIn[FIXED_SIZE-1];
  end
endmodule

// File: rtl/fxp_datapath.sv
module fxp_datapath
  import fxp_to_fp32_pkg::*;
#(
  parameter int FLOAT_SIZE = 32,
  parameter int MANT_BITS  = 23,
  parameter int EXP_BITS   = 8,
  parameter int FIXED_SIZE = 32,
  parameter int RADIX_POS  = 20
) (
  input  logic [FIXED_SIZE-1:0] fixedIn,
  input  ctrl_t                 ctrl,
  output logic [FLOAT_SIZE-1:0] floatOut
);
  localparam int POS_W  = (FIXED_SIZE > 1) ? $clog2(FIXED_SIZE) : 1;
  localparam int BIAS   = (1 << (EXP_BITS - 1)) - 1;
  localparam int FRAC_W = FIXED_SIZE - 1;
  localparam int EXT_W  = FIXED_SIZE + MANT_BITS;

  logic [FIXED_SIZE-1:0] magnitude;
  logic [POS_W-1:0]      leadPos;
  logic                  leadFound;
  logic [POS_W-1:0]      shiftAmt;
  logic [FIXED_SIZE-1:0] normWord;
  logic [EXT_W-1:0]      fracExt;
  logic [MANT_BITS-1:0]  mantissa;
  logic [EXP_BITS-1:0]   expField;
  int                    expVal;

  // unsigned magnitude; most negative value stays 100..0, read as unsigned
  assign magnitude = ctrl.negate ? (~fixedIn + FIXED_SIZE'(1)) : fixedIn;

  fxp_lead_one #(.WIDTH(FIXED_SIZE), .POS_W(POS_W)) uLead (
    .vecIn    (magnitude),
    .leadPos  (leadPos),
    .leadFound(leadFound)
  );

  // move the leading one to the top bit, then take the bits below it
  always_comb begin
    shiftAmt = POS_W'(FRAC_W) - leadPos;
    normWord = magnitude << shiftAmt;
    fracExt  = {normWord, {MANT_BITS{1'b0}}};
    mantissa = MANT_BITS'(fracExt >> FRAC_W);
    expVal   = BIAS + int'(leadPos) - RADIX_POS;
    expField = EXP_BITS'(expVal);
  end

  always_comb begin
    if (ctrl.isZero || !leadFound) floatOut = '0;
    else                           floatOut = {ctrl.negate, expField, mantissa};
  end
endmodule

// File: rtl/fxp_to_fp32.sv
module fxp_to_fp32
  import fxp_to_fp32_pkg::*;
#(
  parameter int FLOAT_SIZE = 32,
  parameter int MANT_BITS  = 23,
  parameter int EXP_BITS   = 8,
  parameter int FIXED_SIZE = 32,
  parameter int RADIX_POS  = 20
) (
  input  logic [FIXED_SIZE-1:0] fixedIn,
  output logic [FLOAT_SIZE-1:0] floatOut
);
  ctrl_t ctrl;

  fxp_ctrl #(.FIXED_SIZE(FIXED_SIZE)) uCtrl (
    .fixedIn(fixedIn),
    .ctrl   (ctrl)
  );

  fxp_datapath #(
    .FLOAT_SIZE(FLOAT_SIZE), .MANT_BITS(MANT_BITS), .EXP_BITS(EXP_BITS),
    .FIXED_SIZE(FIXED_SIZE), .RADIX_POS(RADIX_POS)
  ) uData (
    .fixedIn (fixedIn),
    .ctrl    (ctrl),
    .floatOut(floatOut)
  );
endmodule

// File: rtl/fxp_to_fp32_chk.sv
module fxp_to_fp32_chk #(
  parameter int FLOAT_SIZE = 32,
  parameter int MANT_BITS  = 23,
  parameter int EXP_BITS   = 8,
  parameter int FIXED_SIZE = 32,
  parameter int RADIX_POS  = 20
) (
  input logic [FIXED_SIZE-1:0] fixedIn,
  input logic [FLOAT_SIZE-1:0] floatOut
);
  localparam int BIAS = (1 << (EXP_BITS - 1)) - 1;
  localparam logic [EXP_BITS-1:0] MOST_NEG_EXP = EXP_BITS'(BIAS + FIXED_SIZE - 1 - RADIX_POS);

  logic [EXP_BITS-1:0]  expSeen;
  logic [MANT_BITS-1:0] mantSeen;
  assign expSeen  = floatOut[FLOAT_SIZE-2 -: EXP_BITS];
  assign mantSeen = floatOut[MANT_BITS-1:0];

  always_comb begin
    if (fixedIn == '0) begin
      AST_ZERO_OUT: assert (floatOut == '0); // R1
    end
    if (fixedIn != '0) begin
      AST_SIGN_BIT: assert (floatOut[FLOAT_SIZE-1] == fixedIn[FIXED_SIZE-1]); // R2
    end
    AST_NO_INF_NAN: assert (expSeen != '1); // R6
    if (fixedIn == {1'b1, {(FIXED_SIZE-1){1'b0}}}) begin
      AST_MOST_NEG: assert (mantSeen == '0 && expSeen == MOST_NEG_EXP && floatOut[FLOAT_SIZE-1]); // R5
    end
    if ($countones(fixedIn) == 1 && !fixedIn[FIXED_SIZE-1]) begin
      AST_POW2_MANT: assert (mantSeen == '0); // R7
    end
  end
endmodule

bind fxp_to_fp32 fxp_to_fp32_chk #(
  .FLOAT_SIZE(FLOAT_SIZE), .MANT_BITS(MANT_BITS), .EXP_BITS(EXP_BITS),
  .FIXED_SIZE(FIXED_SIZE), .RADIX_POS(RADIX_POS)
) uChk (
  .fixedIn (fixedIn),
  .floatOut(floatOut)
);

// File: tb/sim_fxp_to_fp32.sv
module sim_fxp_to_fp32;
  localparam int CLK_PERIOD = 10;
  localparam int N0 = 12;
  localparam int R0 = 4;
  localparam int N1 = 32;
  localparam int R1P = 20;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N0-1:0] fix0 = '0;
  logic [31:0]   out0;
  logic [N1-1:0] fix1 = '0;
  logic [31:0]   out1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  fxp_to_fp32 #(.FIXED_SIZE(N0), .RADIX_POS(R0)) u0 (.fixedIn(fix0), .floatOut(out0));
  fxp_to_fp32 #(.FIXED_SIZE(N1), .RADIX_POS(R1P)) u1 (.fixedIn(fix1), .floatOut(out1));

  // arithmetic reference: sign, 127 + msb - radix, fraction bits left-aligned and truncated
  function automatic logic [31:0] model(longint v, int n, int r);
    longint m, frac;
    int msb;
    if (v == 0) return 32'h0;
    m = (v < 0) ? -v : v;
    msb = 0;
    for (int i = 0; i < n; i++) if (m[i]) msb = i;
    frac = m - (longint'(1) << msb);
    if (msb <= 23) frac = frac << (23 - msb);
    else           frac = frac >> (msb - 23);
    return {(v < 0) ? 1'b1 : 1'b0, 8'(127 + msb - r), frac[22:0]};
  endfunction

  task automatic chk(string req, longint v, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in=%0d actual=%h expected=%h", req, v, act, exp);
    end
  endtask

  task automatic checkVec(longint v, int n, int r, logic [31:0] act);
    logic [31:0] e;
    longint m;
    string tag;
    e = model(v, n, r);
    m = (v < 0) ? -v : v;
    if (v == 0)                          tag = "R1";
    else if (v == -(longint'(1) << (n-1))) tag = "R5";
    else if ((m & (m - 1)) == 0)         tag = "R7";
    else                                 tag = "R4";
    chk(tag, v, act, e);
    if (v != 0) begin
      chk("R2 sign", v, {31'b0, act[31]}, {31'b0, e[31]});
      chk("R3 exponent", v, {24'b0, act[30:23]}, {24'b0, e[30:23]});
    end
    chk("R6 exp not all ones", v, {31'b0, act[30:23] == 8'hFF}, 32'h0);
  endtask

  task automatic apply0(longint v);
    @(posedge clk);
    fix0 = N0'(v);
    @(negedge clk);
  endtask

  task automatic apply1(longint v);
    @(posedge clk);
    fix1 = N1'(v);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] posOut;
    logic [31:0] lfsr;
    @(negedge clk);
    chk("R1 initial zero", 0, out0, 32'h0);
    chk("R1 initial zero wide", 0, out1, 32'h0);

    // exhaustive sweep of the small configuration
    for (int v = -(1 << (N0-1)); v < (1 << (N0-1)); v++) begin
      apply0(longint'(v));
      checkVec(longint'(v), N0, R0, out0);
    end

    // R8: negation flips only the sign bit
    for (int v = 1; v < (1 << (N0-1)); v++) begin
      apply0(longint'(v));
      posOut = out0;
      apply0(-longint'(v));
      chk("R8 negate pair", longint'(v), out0, posOut ^ 32'h8000_0000);
    end

    // wide configuration: edges
    apply1(0);                      checkVec(0, N1, R1P, out1);
    apply1(-(longint'(1) << 31));   checkVec(-(longint'(1) << 31), N1, R1P, out1);
    chk("R5 most negative exact", -(longint'(1) << 31), out1, {1'b1, 8'(127 + 31 - R1P), 23'h0});
    apply1((longint'(1) << 31) - 1); checkVec((longint'(1) << 31) - 1, N1, R1P, out1);
    apply1(-1);                     checkVec(-1, N1, R1P, out1);
    for (int k = 0; k < 31; k++) begin
      apply1(longint'(1) << k);
      checkVec(longint'(1) << k, N1, R1P, out1);
      chk("R7 pow2 mantissa", longint'(1) << k, {9'b0, out1[22:0]}, 32'h0);
      apply1(-(longint'(1) << k));
      checkVec(-(longint'(1) << k), N1, R1P, out1);
    end

    // wide configuration: pseudo-random, exercises truncation (R4)
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply1(longint'(signed'(lfsr)));
      checkVec(longint'(signed'(lfsr)), N1, R1P, out1);
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule